// File: doc/BRIEF.md
# Asynchronous Chip-Select Memory Controller

This block turns single requests from an internal port into timed accesses on an external 16-bit asynchronous memory bus. The bus has four active-low chip-select lines, a shared output enable, a shared write enable, a halfword address, a data bus split into input and output halves, and two active-low byte enables. A request names a chip select, a byte address, a direction, a size of 16 or 32 bits, write data and four byte strobes. The block raises `done` for one cycle when the request has finished. For reads, the returned word is valid in that same cycle.

Each chip select has its own 32-bit configuration register, written and read through a small register port. The register sets the read mode, the write wait-state count, the write-enable pulse width, the page-hit read wait count, a bus-width flag, and an address-fix flag. The address-fix flag decides where the second half of a split 32-bit write lands. A 32-bit request always becomes two 16-bit beats, low halfword first. The block copies the target's configuration when it accepts the request, so software may rewrite a register while an access is in flight.

Top module: `acs_memctl`

## Requirements
- R1: After reset, the configuration registers read 0x0000FF00 for chip selects 0 and 3. They read 0x0010FF00 for chip selects 1 and 2, because bit 20 is the bus-width flag and it resets to 1 there.
- R2: The writable configuration bits are bit 21 (address fix), bit 20 (bus width), bits 18:16 (read mode), bits 15:12 (strobe length) and bits 11:8 (write wait count). Every other bit reads 0 whatever is written.
- R3: A 32-bit write with address fix 0 drives two beats. The first drives write data 15:0 with byte enables equal to the inverse of strobes 1:0 at halfword address A, where A is the byte address shifted right by one. The second drives data 31:16 with the inverse of strobes 3:2 at A+1.
- R4: With address fix 1, both beats of a 32-bit write use address A. A 32-bit read still uses A and then A+1.
- R5: A write beat has four phases, in this order. One setup cycle with only the chip select low. Then as many cycles as bits 11:8 give, with write enable high. Then write enable low for max(bits 15:12, 1) cycles. Then one hold cycle with write enable high.
- R6: When the read mode is any code other than 001, a read beat has one setup cycle, then output enable low for 4 cycles, then one hold cycle. Read data is taken in the last output-enable cycle, and byte enables are both low throughout.
- R7: In read mode 001, a read beat uses max(bits 15:12, 1) output-enable cycles when the previous read beat was on the same chip select, in the same 8-halfword page (halfword address bits above bit 2), and no write beat came in between. Otherwise it uses 4 cycles.
- R8: A request to a chip select whose bus-width bit is 1 raises `done` and `err` in the cycle after acceptance, and drives no chip select.
- R9: A 32-bit read returns the first beat in bits 15:0 and the second beat in bits 31:16. A 16-bit read returns zero in bits 31:16.
- R10: At most one chip-select line is low, and it is the requested one. When no access is running, the bus is idle: all selects high, both enables high, address 0, data 0, data enable 0, byte enables 11.
- R11: Within a write beat, the address, data and byte enables stay constant from setup to hold, with the data enable high. Output enable and the data enable are never active together.
- R12: `done` is a one-cycle pulse in the cycle after the last hold cycle. `busy` is high from acceptance until `done` has ended, and requests presented while `busy` is high are ignored.
- R13: Timing and mode are copied at acceptance. A configuration write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Selected configuration register value |
| reqValid | input | 1 | Request present (accepted when not busy) |
| reqCs | input | 2 | Target chip select |
| reqAddr | input | 24 | Byte address |
| reqWrite | input | 1 | 1 write, 0 read |
| reqWide | input | 1 | 1 for 32-bit, 0 for 16-bit |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte strobes, active high |
| busy | output | 1 | Access in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Completion with error (valid with done) |
| rdData | output | 32 | Read result (valid with done) |
| memCsN | output | 4 | Chip selects, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | 23 | Halfword address |
| memDout | output | 16 | Data driven to memory |
| memDoutEn | output | 1 | Data bus drive enable |
| memBeN | output | 2 | Byte enables, active low |
| memDin | input | 16 | Data returned by memory |

## Verification
Two things can happen in the same cycle: a configuration write lands on the register of the chip select that is mid-access, and a new request is held valid while the controller is busy or sitting in its `done` cycle. The bench provokes both. It rewrites the active chip select's timing in the middle of a split 32-bit write and holds a stray request across the tail of that write. The reference model builds the whole expected bus sequence from the configuration at acceptance, and predicts no second access for the stray request. Every output is compared on every cycle, so a transfer that picked up the new timing, or a request accepted too early, shows up as a mismatch in that cycle.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;
  // Configuration field positions; other logic decodes these, so they are fixed.
  localparam int FIX_BIT = 21;
  localparam int WIDE_BIT = 20;
  localparam int MODE_LSB = 16;
  localparam int LEN_LSB = 12;
  localparam int WWAIT_LSB = 8;
  localparam logic [31:0] CFG_WRITABLE = 32'h0037_FF00;
  localparam logic [31:0] CFG_BASE_RESET = 32'h0000_FF00;
  localparam logic [2:0] MODE_PAGE = 3'b001;

  typedef struct packed {
    logic       fixAddr;
    logic       wide;
    logic [2:0] rdMode;
    logic [3:0] strobeLen;
    logic [3:0] wrWait;
  } cs_cfg_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
    logic window;
    logic oeOn;
    logic weOn;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WAIT, ST_STROBE, ST_HOLD, ST_DONE
  } state_t;

  function automatic cs_cfg_t unpackCfg(input logic [31:0] r);
    cs_cfg_t c;
    c.fixAddr   = r[FIX_BIT];
    c.wide      = r[WIDE_BIT];
    c.rdMode    = r[MODE_LSB +: 3];
    c.strobeLen = r[LEN_LSB +: 4];
    c.wrWait    = r[WWAIT_LSB +: 4];
    return c;
  endfunction
endpackage

// File: rtl/acs_cfg_regs.sv
`timescale 1ns/1ps
module acs_cfg_regs
  import acs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter logic [NUM_CS-1:0] WIDE_RESET = 'b0110,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [31:0]      cfgWdata,
  output logic [31:0]      cfgRdata,
  input  logic [SEL_W-1:0] lookSel,
  output cs_cfg_t          lookCfg
);
  logic [31:0] regs [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    localparam logic [31:0] RESET_VAL =
      CFG_BASE_RESET | (WIDE_RESET[g] ? (32'h1 << WIDE_BIT) : 32'h0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[g] <= RESET_VAL;
      end else if (cfgWe && (cfgSel == SEL_W'(g))) begin
        regs[g] <= cfgWdata & CFG_WRITABLE;
      end
    end
  end

  assign cfgRdata = regs[cfgSel];
  assign lookCfg  = unpackCfg(regs[lookSel]);
endmodule

// File: rtl/acs_ctrl.sv
`timescale 1ns/1ps
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int FIXED_WAIT = 4,
  parameter int TAG_W = 20,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int CNT_W = (FIXED_WAIT > 15) ? $clog2(FIXED_WAIT + 1) : 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqWide,
  input  logic [SEL_W-1:0] reqCs,
  input  logic             cfgWide,
  input  logic [2:0]       cfgMode,
  input  logic [3:0]       cfgLen,
  input  logic [3:0]       cfgWait,
  input  logic [TAG_W-1:0] beatTag,
  output strobe_t          stb,
  output logic             busy,
  output logic             done,
  output logic             err
);
  state_t state;
  logic [CNT_W-1:0] cnt;
  logic isWr, two, beat, errFlag;
  logic [2:0] modeL;
  logic [3:0] lenL, waitL;
  logic [SEL_W-1:0] csL;
  logic pageValid;
  logic [SEL_W-1:0] pageCs;
  logic [TAG_W-1:0] pageTag;

  logic [CNT_W-1:0] lenM1, fixedM1, readM1;
  logic pageHit;

  assign fixedM1 = CNT_W'(FIXED_WAIT - 1);
  assign lenM1   = (lenL == 4'd0) ? '0 : (CNT_W'(lenL) - CNT_W'(1));
  assign pageHit = (modeL == MODE_PAGE) && pageValid && (pageCs == csL) && (pageTag == beatTag);
  assign readM1  = pageHit ? lenM1 : fixedM1;

  always_comb begin
    stb         = '0;
    stb.window  = (state == ST_SETUP) || (state == ST_WAIT) || (state == ST_STROBE) || (state == ST_HOLD);
    stb.oeOn    = (state == ST_STROBE) && !isWr;
    stb.weOn    = (state == ST_STROBE) && isWr;
    stb.load    = (state == ST_IDLE) && reqValid && !cfgWide;
    stb.capture = (state == ST_STROBE) && (cnt == '0) && !isWr;
    stb.advance = (state == ST_HOLD) && two && !beat;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign err  = (state == ST_DONE) && errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      isWr      <= 1'b0;
      two       <= 1'b0;
      beat      <= 1'b0;
      errFlag   <= 1'b0;
      modeL     <= '0;
      lenL      <= '0;
      waitL     <= '0;
      csL       <= '0;
      pageValid <= 1'b0;
      pageCs    <= '0;
      pageTag   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (cfgWide) begin
              state   <= ST_DONE;
              errFlag <= 1'b1;
            end else begin
              state   <= ST_SETUP;
              errFlag <= 1'b0;
              isWr    <= reqWrite;
              two     <= reqWide;
              beat    <= 1'b0;
              modeL   <= cfgMode;
              lenL    <= cfgLen;
              waitL   <= cfgWait;
              csL     <= reqCs;
            end
          end
        end
        ST_SETUP: begin
          if (isWr) begin
            pageValid <= 1'b0;
            if (waitL != 4'd0) begin
              state <= ST_WAIT;
              cnt   <= CNT_W'(waitL) - CNT_W'(1);
            end else begin
              state <= ST_STROBE;
              cnt   <= lenM1;
            end
          end else begin
            state <= ST_STROBE;
            cnt   <= readM1;
            if (modeL == MODE_PAGE) begin
              pageValid <= 1'b1;
              pageCs    <= csL;
              pageTag   <= beatTag;
            end else begin
              pageValid <= 1'b0;
            end
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= lenM1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_STROBE: begin
          if (cnt == '0) state <= ST_HOLD;
          else cnt <= cnt - CNT_W'(1);
        end
        ST_HOLD: begin
          if (two && !beat) begin
            beat  <= 1'b1;
            state <= ST_SETUP;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acs_datapath.sv
`timescale 1ns/1ps
module acs_datapath
  import acs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int HW_W = 23,
  parameter int PAGE_BITS = 3,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int TAG_W = HW_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [HW_W-1:0]   reqHw,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  input  logic [SEL_W-1:0]  reqCs,
  input  logic              reqWrite,
  input  logic              reqFix,
  input  logic [15:0]       memDin,
  output logic [TAG_W-1:0]  beatTag,
  output logic [31:0]       rdData,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [HW_W-1:0]   memAddr,
  output logic [15:0]       memDout,
  output logic              memDoutEn,
  output logic [1:0]        memBeN
);
  logic [HW_W-1:0]  baseHw;
  logic [31:0]      wdataR;
  logic [3:0]       beR;
  logic [SEL_W-1:0] csR;
  logic             wrR, fixR, beat1;
  logic [HW_W-1:0]  beatHw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHw <= '0;
      wdataR <= '0;
      beR    <= '0;
      csR    <= '0;
      wrR    <= 1'b0;
      fixR   <= 1'b0;
      beat1  <= 1'b0;
      rdData <= '0;
    end else begin
      if (stb.load) begin
        baseHw <= reqHw;
        wdataR <= reqWdata;
        beR    <= reqBe;
        csR    <= reqCs;
        wrR    <= reqWrite;
        fixR   <= reqFix;
        beat1  <= 1'b0;
      end else if (stb.advance) begin
        beat1 <= 1'b1;
      end
      if (stb.capture) begin
        if (beat1) rdData[31:16] <= memDin;
        else rdData <= {16'h0000, memDin};
      end
    end
  end

  // Second beat steps one halfword unless a fixed-address write is in progress.
  assign beatHw  = baseHw + ((beat1 && !(wrR && fixR)) ? HW_W'(1) : HW_W'(0));
  assign beatTag = beatHw[HW_W-1:PAGE_BITS];

  always_comb begin
    memCsN    = '1;
    memAddr   = '0;
    memDout   = '0;
    memDoutEn = 1'b0;
    memBeN    = 2'b11;
    if (stb.window) begin
      memCsN[csR] = 1'b0;
      memAddr     = beatHw;
      if (wrR) begin
        memDout   = beat1 ? wdataR[31:16] : wdataR[15:0];
        memDoutEn = 1'b1;
        memBeN    = ~(beat1 ? beR[3:2] : beR[1:0]);
      end else begin
        memBeN = 2'b00;
      end
    end
  end

  assign memOeN = ~stb.oeOn;
  assign memWeN = ~stb.weOn;
endmodule

// File: rtl/acs_memctl.sv
`timescale 1ns/1ps
module acs_memctl
  import acs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4,
  parameter int FIXED_WAIT = 4,
  parameter int PAGE_HW = 8,
  parameter logic [NUM_CS-1:0] WIDE_RESET = 'b0110,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int HW_W = ADDR_W - 1,
  localparam int PAGE_BITS = $clog2(PAGE_HW),
  localparam int TAG_W = HW_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              reqValid,
  input  logic [SEL_W-1:0]  reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdData,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [HW_W-1:0]   memAddr,
  output logic [15:0]       memDout,
  output logic              memDoutEn,
  output logic [1:0]        memBeN,
  input  logic [15:0]       memDin
);
  cs_cfg_t          tgtCfg;
  strobe_t          stb;
  logic [TAG_W-1:0] beatTag;
  logic             unusedByteBit;

  assign unusedByteBit = reqAddr[0];

  acs_cfg_regs #(.NUM_CS(NUM_CS), .WIDE_RESET(WIDE_RESET)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .lookSel(reqCs), .lookCfg(tgtCfg)
  );

  acs_ctrl #(.NUM_CS(NUM_CS), .FIXED_WAIT(FIXED_WAIT), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqWide(reqWide),
    .reqCs(reqCs), .cfgWide(tgtCfg.wide), .cfgMode(tgtCfg.rdMode), .cfgLen(tgtCfg.strobeLen),
    .cfgWait(tgtCfg.wrWait), .beatTag(beatTag), .stb(stb), .busy(busy), .done(done), .err(err)
  );

  acs_datapath #(.NUM_CS(NUM_CS), .HW_W(HW_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqHw(reqAddr[ADDR_W-1:1]), .reqWdata(reqWdata),
    .reqBe(reqBe), .reqCs(reqCs), .reqWrite(reqWrite), .reqFix(tgtCfg.fixAddr),
    .memDin(memDin), .beatTag(beatTag), .rdData(rdData), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn), .memBeN(memBeN)
  );
endmodule

// File: rtl/acs_memctl_chk.sv
`timescale 1ns/1ps
module acs_memctl_chk #(
  parameter int NUM_CS = 4,
  parameter int HW_W = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [HW_W-1:0]   memAddr,
  input logic [15:0]       memDout,
  input logic              memDoutEn,
  input logic              done,
  input logic              err
);
  // R10: never more than one select low
  p_one_select_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R5: write enable opens only after a cycle of chip select alone
  p_we_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memCsN) != '1) && $past(memWeN) && $past(memOeN));

  // R5: chip select still low in the cycle after write enable closes
  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memCsN != '1));

  // R6: output enable only inside a chip-select window
  p_oe_in_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memCsN != '1) && memWeN);

  // R11: data and address unchanged in the cycle after write enable was low
  p_wdata_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(memWeN) |-> $stable(memDout) && $stable(memAddr) && memDoutEn);

  // R11: no drive conflict with the memory
  p_no_contention_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memDoutEn && !memOeN));

  // R12: done lasts a single cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an error completion follows a cycle with no select active
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done && ($past(memCsN) == '1));
endmodule

bind acs_memctl acs_memctl_chk #(.NUM_CS(NUM_CS), .HW_W(HW_W)) u_chk (
  .clk(clk), .rstN(rstN), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
  .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn), .done(done), .err(err)
);

// File: tb/acs_memctl_test.sv
`timescale 1ns/1ps
module acs_memctl_test;
  localparam int HW_W = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic reqValid = 1'b0;
  logic [1:0] reqCs = '0;
  logic [23:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic reqWide = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [3:0] reqBe = '0;
  logic busy, done, err;
  logic [31:0] rdData;
  logic [3:0] memCsN;
  logic memOeN, memWeN;
  logic [HW_W-1:0] memAddr;
  logic [15:0] memDout;
  logic memDoutEn;
  logic [1:0] memBeN;
  logic [15:0] memDin;

  always #2.5 clk = ~clk;

  acs_memctl uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqValid(reqValid), .reqCs(reqCs), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqWdata(reqWdata), .reqBe(reqBe),
    .busy(busy), .done(done), .err(err), .rdData(rdData), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr), .memDout(memDout),
    .memDoutEn(memDoutEn), .memBeN(memBeN), .memDin(memDin)
  );

  function automatic logic [15:0] memVal(input logic [HW_W-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign memDin = memOeN ? 16'h0000 : memVal(memAddr);

  typedef struct packed {
    logic [3:0] csN;
    logic oeN;
    logic weN;
    logic [HW_W-1:0] addr;
    logic [15:0] dout;
    logic doutEn;
    logic [1:0] beN;
    logic dn;
    logic er;
    logic chkRd;
    logic [31:0] rd;
  } exp_t;

  exp_t q[$];
  logic [31:0] cfgM [4];
  bit pv = 0;
  int pcs = 0;
  logic [HW_W-1:0] ptag = '0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R10";

  function automatic exp_t idleExp();
    exp_t e;
    e.csN = 4'hF; e.oeN = 1'b1; e.weN = 1'b1; e.addr = '0; e.dout = '0;
    e.doutEn = 1'b0; e.beN = 2'b11; e.dn = 1'b0; e.er = 1'b0; e.chkRd = 1'b0; e.rd = '0;
    return e;
  endfunction

  function automatic logic [31:0] mkCfg(bit fx, bit wd, logic [2:0] md, logic [3:0] ln, logic [3:0] ww);
    return (32'(fx) << 21) | (32'(wd) << 20) | (32'(md) << 16) | (32'(ln) << 12) | (32'(ww) << 8);
  endfunction

  task automatic checkCycle();
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = idleExp();
    checks++;
    if (memCsN !== e.csN || memOeN !== e.oeN || memWeN !== e.weN || memAddr !== e.addr ||
        memDout !== e.dout || memDoutEn !== e.doutEn || memBeN !== e.beN ||
        done !== e.dn || err !== e.er || (e.chkRd && rdData !== e.rd)) begin
      errors++;
      $display("FAIL %s t=%0t actual cs=%h oe=%b we=%b a=%h d=%h en=%b be=%b dn=%b er=%b rd=%h expected cs=%h oe=%b we=%b a=%h d=%h en=%b be=%b dn=%b er=%b rd=%h",
               tag, $time, memCsN, memOeN, memWeN, memAddr, memDout, memDoutEn, memBeN, done, err, rdData,
               e.csN, e.oeN, e.weN, e.addr, e.dout, e.doutEn, e.beN, e.dn, e.er, e.rd);
    end
  endtask

  task automatic step();
    @(negedge clk);
    checkCycle();
  endtask

  task automatic chkVal(string t, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, expv);
    end
  endtask

  task automatic pushBus(int cs, bit oe, bit we, logic [HW_W-1:0] a, logic [15:0] d, bit en, logic [1:0] be);
    exp_t e = idleExp();
    e.csN[cs] = 1'b0; e.oeN = oe; e.weN = we; e.addr = a; e.dout = d; e.doutEn = en; e.beN = be;
    q.push_back(e);
  endtask

  // Reference: builds the full expected bus sequence at acceptance.
  task automatic issue(int cs, logic [23:0] addr, bit wr, bit wide, logic [31:0] wd, logic [3:0] be);
    logic [31:0] c;
    exp_t e;
    logic [31:0] rdv;
    c = cfgM[cs];
    rdv = '0;
    reqValid = 1'b1; reqCs = 2'(cs); reqAddr = addr; reqWrite = wr; reqWide = wide;
    reqWdata = wd; reqBe = be;
    if (c[20]) begin
      e = idleExp(); e.dn = 1'b1; e.er = 1'b1; q.push_back(e);
    end else begin
      for (int b = 0; b < (wide ? 2 : 1); b++) begin
        logic [HW_W-1:0] hw;
        int ln;
        hw = addr[23:1] + ((b == 1 && !(wr && c[21])) ? HW_W'(1) : HW_W'(0));
        if (wr) begin
          logic [15:0] d;
          logic [1:0] bn;
          d = (b == 1) ? wd[31:16] : wd[15:0];
          bn = (b == 1) ? ~be[3:2] : ~be[1:0];
          pv = 0;
          ln = (c[15:12] == 0) ? 1 : int'(c[15:12]);
          pushBus(cs, 1, 1, hw, d, 1, bn);
          for (int i = 0; i < int'(c[11:8]); i++) pushBus(cs, 1, 1, hw, d, 1, bn);
          for (int i = 0; i < ln; i++) pushBus(cs, 1, 0, hw, d, 1, bn);
          pushBus(cs, 1, 1, hw, d, 1, bn);
        end else begin
          if (c[18:16] == 3'b001 && pv && pcs == cs && ptag == (hw >> 3))
            ln = (c[15:12] == 0) ? 1 : int'(c[15:12]);
          else ln = 4;
          if (c[18:16] == 3'b001) begin pv = 1; pcs = cs; ptag = hw >> 3; end
          else pv = 0;
          pushBus(cs, 1, 1, hw, 16'h0, 0, 2'b00);
          for (int i = 0; i < ln; i++) pushBus(cs, 0, 1, hw, 16'h0, 0, 2'b00);
          pushBus(cs, 1, 1, hw, 16'h0, 0, 2'b00);
          if (b == 1) rdv[31:16] = memVal(hw);
          else rdv[15:0] = memVal(hw);
        end
      end
      e = idleExp(); e.dn = 1'b1; e.chkRd = !wr; e.rd = rdv; q.push_back(e);
    end
    step();
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
  endtask

  task automatic wrCfg(int sel, logic [31:0] v);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgWdata = v;
    step();
    cfgWe = 1'b0;
    cfgM[sel] = v & 32'h0037_FF00;
  endtask

  initial begin
    cfgM[0] = 32'h0000_FF00; cfgM[1] = 32'h0010_FF00;
    cfgM[2] = 32'h0010_FF00; cfgM[3] = 32'h0000_FF00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset readback and R10 idle bus
    for (int i = 0; i < 4; i++) begin
      cfgSel = 2'(i); #1;
      chkVal("R1", cfgRdata, cfgM[i]);
    end
    tag = "R10"; step();

    // R2 reserved bits
    tag = "R2";
    wrCfg(0, 32'hFFFF_FFFF);
    cfgSel = 2'd0; #1; chkVal("R2", cfgRdata, 32'h0037_FF00);
    wrCfg(3, 32'hFFC8_00FF);
    cfgSel = 2'd3; #1; chkVal("R2", cfgRdata, 32'h0000_0000);

    // R8 width flag still set on CS1
    tag = "R8";
    issue(1, 24'h000040, 0, 1, 32'h0, 4'h0); drain();
    issue(1, 24'h000044, 1, 0, 32'h1111_2222, 4'hF); drain();

    // R3 split write, incrementing address; R5 timing with waits
    tag = "R3";
    wrCfg(0, mkCfg(0, 0, 3'b000, 4'd3, 4'd2));
    issue(0, 24'h000100, 1, 1, 32'hCAFE_1234, 4'b1101); drain();

    // R5 zero wait and zero strobe field on CS2 after clearing width; R10 select line
    tag = "R5";
    wrCfg(2, mkCfg(0, 0, 3'b000, 4'd0, 4'd0));
    issue(2, 24'h00ABCE, 1, 0, 32'h0000_BEEF, 4'b0010); drain();
    tag = "R10";
    issue(2, 24'h7FFFFE, 1, 1, 32'h5555_AAAA, 4'hF); drain();

    // R4 fixed address on writes, reads still increment; R9 assembly
    tag = "R4";
    wrCfg(0, mkCfg(1, 0, 3'b000, 4'd2, 4'd1));
    issue(0, 24'h000200, 1, 1, 32'h89AB_CDEF, 4'b1111); drain();
    tag = "R9";
    issue(0, 24'h000300, 0, 1, 32'h0, 4'h0); drain();

    // R6 plain read, including an unused mode code
    tag = "R6";
    issue(0, 24'h0002A4, 0, 0, 32'h0, 4'h0); drain();
    wrCfg(0, mkCfg(0, 0, 3'b110, 4'd1, 4'd0));
    issue(0, 24'h0002A6, 0, 0, 32'h0, 4'h0); drain();

    // R7 page mode on CS3
    tag = "R7";
    wrCfg(3, mkCfg(0, 0, 3'b001, 4'd2, 4'd0));
    issue(3, 24'h000020, 0, 1, 32'h0, 4'h0); drain();
    issue(3, 24'h000026, 0, 0, 32'h0, 4'h0); drain();
    issue(3, 24'h000030, 0, 0, 32'h0, 4'h0); drain();
    issue(3, 24'h000032, 1, 0, 32'h0000_7777, 4'b0011); drain();
    issue(3, 24'h000034, 0, 0, 32'h0, 4'h0); drain();
    issue(3, 24'h00002E, 0, 1, 32'h0, 4'h0); drain();
    wrCfg(3, mkCfg(0, 0, 3'b001, 4'd0, 4'd0));
    issue(3, 24'h000034, 0, 0, 32'h0, 4'h0); drain();
    issue(0, 24'h000034, 0, 0, 32'h0, 4'h0); drain();

    // R13 and R12: config write and stray request during an access
    tag = "R13";
    wrCfg(0, mkCfg(0, 0, 3'b000, 4'd3, 4'd2));
    issue(0, 24'h000500, 1, 1, 32'h1357_9BDF, 4'b1111);
    step();
    cfgWe = 1'b1; cfgSel = 2'd0; cfgWdata = mkCfg(0, 0, 3'b000, 4'd1, 4'd0);
    step();
    cfgWe = 1'b0;
    cfgM[0] = mkCfg(0, 0, 3'b000, 4'd1, 4'd0);
    tag = "R12";
    while (q.size() > 1) step();
    reqValid = 1'b1; reqCs = 2'd0; reqAddr = 24'h000700; reqWrite = 1'b0; reqWide = 1'b0;
    checks++;
    if (busy !== 1'b1) begin errors++; $display("FAIL R12 busy actual %b expected 1", busy); end
    step();
    reqValid = 1'b0;
    drain();
    tag = "R13";
    issue(0, 24'h000600, 1, 0, 32'h0000_4242, 4'b0001); drain();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule